// File: doc/BRIEF.md
# Bidirectional Doorbell Mailbox

This block couples a host processor and a DSP through a small shared register file. Traffic runs in two directions. The inbound direction carries requests toward the DSP. The outbound direction carries requests toward the host. Each direction has three parts:

- a doorbell register of independent channel bits;
- a write-ones-to-clear register that acknowledges those bits;
- a bank of 32-bit scratch words for short message payloads.

A direction's interrupt line stays high for as long as any of its doorbell bits is set.

Both processors reach the same map at the same word offsets, each through its own simple register port. A port has a select, a write enable, a word address and write data. Read data comes back one cycle after the request.

When both ports act on the same cycle, the result is defined as follows:

- doorbell sets from the two ports merge;
- a set beats a clear of the same bit, so no ring is lost;
- for scratch words the host port wins.

Widths, channel count and bank depth are parameters.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every doorbell and scratch word reads zero and both interrupt outputs are low.
- R2: The word map per direction is doorbell, clear, then MSG_N scratch words. The inbound direction starts at offset 0 (doorbell 0, clear 1, scratch 2 to 6) and the outbound direction follows (doorbell 7, clear 8, scratch 9 to 13). This gives 14 words with the defaults.
- R3: A write to a doorbell register sets each channel bit where the written word has a one. Zero bits leave the existing bits unchanged, so bits already set are preserved.
- R4: `irq_to_dsp` is high exactly while the inbound doorbell is nonzero. `irq_to_host` is high exactly while the outbound doorbell is nonzero. Each follows the register write that changes it, in the same clock edge.
- R5: A write to a clear register clears each doorbell bit of that direction where the written word has a one. All other bits are unchanged.
- R6: When a set and a clear of the same doorbell bit occur in one cycle (from the two ports), the bit ends set.
- R7: When both ports write the same doorbell register in one cycle, the result holds the union of both ports' set bits.
- R8: Scratch words are readable and writable from both ports. When both ports write the same word in one cycle, the host port's value is stored.
- R9: A doorbell read returns the channel bits in bits [CHAN_N-1:0] with zeros above them. A clear register always reads zero.
- R10: Accesses at offsets 14 and above change no register, and reads there return zero.
- R11: Read data appears on the port's rdata one cycle after the read request. It shows the register contents before any write made in the same cycle, and it holds until the next read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host port access request |
| host_we | input | 1 | Host port write (1) or read (0) |
| host_addr | input | ADDR_W | Host port word offset |
| host_wdata | input | DATA_W | Host port write data |
| host_rdata | output | DATA_W | Host port read data, registered |
| dsp_sel | input | 1 | DSP port access request |
| dsp_we | input | 1 | DSP port write (1) or read (0) |
| dsp_addr | input | ADDR_W | DSP port word offset |
| dsp_wdata | input | DATA_W | DSP port write data |
| dsp_rdata | output | DATA_W | DSP port read data, registered |
| irq_to_dsp | output | 1 | Level interrupt, inbound doorbell nonzero |
| irq_to_host | output | 1 | Level interrupt, outbound doorbell nonzero |

## Verification
The assertions check the following on every cycle:

- doorbell bits are kept unless a clear is written;
- a host clear drops its bits by the next cycle;
- a DSP set lands even against a same-cycle clear;
- an inbound interrupt only rises after a nonzero doorbell write;
- clear-register and out-of-range reads return zero.

Several behaviours need the bench's ordered scenarios:

- the exact offset layout;
- zero extension of doorbell reads;
- host priority on scratch collisions;
- merging of simultaneous sets;
- read-before-write data on a same-cycle collision.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int NUM_LANES = 2;
   localparam int NUM_PORTS = 2;
   localparam int PORT_HOST = 0;
   localparam int PORT_DSP  = 1;

   typedef enum logic [1:0] {
      FLD_NONE = 2'd0,
      FLD_CMD  = 2'd1,
      FLD_CLR  = 2'd2,
      FLD_MSG  = 2'd3
   } mbx_field_e;

   // words occupied by one direction: doorbell, clear, scratch bank
   function automatic int lane_span(input int msg_n);
      return 2 + msg_n;
   endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode import mbx_pkg::*; #(
   parameter int ADDR_W = 4,
   parameter int MSG_N  = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output mbx_field_e        field,
   output logic              dir,
   output logic [MSG_N-1:0]  msg_sel
);
   localparam int SPAN = lane_span(MSG_N);
   localparam logic [ADDR_W:0] SPAN_X = (ADDR_W+1)'(SPAN);
   localparam logic [ADDR_W:0] MAP_X  = (ADDR_W+1)'(2 * SPAN);

   logic [ADDR_W:0] a_ext;
   logic [ADDR_W:0] off;
   logic            hit;

   assign a_ext = {1'b0, addr};

   always_comb begin
      hit = 1'b1;
      dir = 1'b0;
      off = a_ext;
      if (a_ext < SPAN_X) begin
         dir = 1'b0;
         off = a_ext;
      end else if (a_ext < MAP_X) begin
         dir = 1'b1;
         off = a_ext - SPAN_X;
      end else begin
         hit = 1'b0;
      end
   end

   always_comb begin
      field   = FLD_NONE;
      msg_sel = '0;
      if (hit) begin
         if (off == '0) begin
            field = FLD_CMD;
         end else if (off == (ADDR_W+1)'(1)) begin
            field = FLD_CLR;
         end else begin
            field = FLD_MSG;
            for (int i = 0; i < MSG_N; i++) begin
               if (off == (ADDR_W+1)'(i + 2)) msg_sel[i] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mbx_lane.sv
module mbx_lane import mbx_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int CHAN_N = 5,
   parameter int MSG_N  = 5
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_PORTS-1:0]                 wr_cmd,
   input  logic [NUM_PORTS-1:0]                 wr_clr,
   input  logic [NUM_PORTS-1:0][MSG_N-1:0]      wr_msg,
   input  logic [NUM_PORTS-1:0][DATA_W-1:0]     wdata,
   output logic [CHAN_N-1:0]                    cmd,
   output logic [MSG_N-1:0][DATA_W-1:0]         msg,
   output logic                                 irq
);
   logic [CHAN_N-1:0] cmd_q;
   logic [CHAN_N-1:0] set_v;
   logic [CHAN_N-1:0] clr_v;

   // gather set and clear masks from every port
   always_comb begin
      set_v = '0;
      clr_v = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (wr_cmd[p]) set_v = set_v | wdata[p][CHAN_N-1:0];
         if (wr_clr[p]) clr_v = clr_v | wdata[p][CHAN_N-1:0];
      end
   end

   // set is applied after clear so a coincident ring survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= '0;
      else        cmd_q <= (cmd_q & ~clr_v) | set_v;
   end

   assign cmd = cmd_q;
   assign irq = |cmd_q;

   for (genvar i = 0; i < MSG_N; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   word_q <= '0;
         else if (wr_msg[PORT_HOST][i]) word_q <= wdata[PORT_HOST];
         else if (wr_msg[PORT_DSP][i])  word_q <= wdata[PORT_DSP];
      end
      assign msg[i] = word_q;
   end

endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport import mbx_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int CHAN_N = 5,
   parameter int MSG_N  = 5
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        rd_en,
   input  mbx_field_e                                  field,
   input  logic                                        dir,
   input  logic [MSG_N-1:0]                            msg_sel,
   input  logic [NUM_LANES-1:0][CHAN_N-1:0]            cmd,
   input  logic [NUM_LANES-1:0][MSG_N-1:0][DATA_W-1:0] msg,
   output logic [DATA_W-1:0]                           rdata
);
   logic [DATA_W-1:0] val;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      val = '0;
      case (field)
         FLD_CMD: val[CHAN_N-1:0] = cmd[dir];
         FLD_MSG: begin
            for (int i = 0; i < MSG_N; i++) begin
               if (msg_sel[i]) val = val | msg[dir][i];
            end
         end
         default: val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= val;
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox import mbx_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int CHAN_N = 5,
   parameter int MSG_N  = 5,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              dsp_sel,
   input  logic              dsp_we,
   input  logic [ADDR_W-1:0] dsp_addr,
   input  logic [DATA_W-1:0] dsp_wdata,
   output logic [DATA_W-1:0] dsp_rdata,
   output logic              irq_to_dsp,
   output logic              irq_to_host
);
   localparam int SPAN      = lane_span(MSG_N);
   localparam int MAP_WORDS = NUM_LANES * SPAN;

   if (CHAN_N < 1 || CHAN_N > DATA_W) begin : g_bad_chan
      $error("ipc_mailbox: CHAN_N must lie in 1..DATA_W");
   end
   if (MSG_N < 1) begin : g_bad_msg
      $error("ipc_mailbox: MSG_N must be at least 1");
   end
   if ((1 << ADDR_W) < MAP_WORDS) begin : g_bad_addr
      $error("ipc_mailbox: ADDR_W too narrow for the register map");
   end

   logic [NUM_PORTS-1:0]                    p_sel;
   logic [NUM_PORTS-1:0]                    p_we;
   logic [NUM_PORTS-1:0][ADDR_W-1:0]        p_addr;
   logic [NUM_PORTS-1:0][DATA_W-1:0]        p_wdata;
   logic [NUM_PORTS-1:0][DATA_W-1:0]        p_rdata;
   mbx_field_e                              p_field [NUM_PORTS];
   logic [NUM_PORTS-1:0]                    p_dir;
   logic [NUM_PORTS-1:0][MSG_N-1:0]         p_msg_sel;

   logic [NUM_LANES-1:0][CHAN_N-1:0]        lane_cmd;
   logic [NUM_LANES-1:0][MSG_N-1:0][DATA_W-1:0] lane_msg;
   logic [NUM_LANES-1:0]                    lane_irq;

   assign p_sel   = {dsp_sel,   host_sel};
   assign p_we    = {dsp_we,    host_we};
   assign p_addr  = {dsp_addr,  host_addr};
   assign p_wdata = {dsp_wdata, host_wdata};

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      mbx_decode #(
         .ADDR_W (ADDR_W),
         .MSG_N  (MSG_N)
      ) u_dec (
         .addr    (p_addr[p]),
         .field   (p_field[p]),
         .dir     (p_dir[p]),
         .msg_sel (p_msg_sel[p])
      );

      mbx_rdport #(
         .DATA_W (DATA_W),
         .CHAN_N (CHAN_N),
         .MSG_N  (MSG_N)
      ) u_rd (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_en   (p_sel[p] & ~p_we[p]),
         .field   (p_field[p]),
         .dir     (p_dir[p]),
         .msg_sel (p_msg_sel[p]),
         .cmd     (lane_cmd),
         .msg     (lane_msg),
         .rdata   (p_rdata[p])
      );
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [NUM_PORTS-1:0]            wr_cmd;
      logic [NUM_PORTS-1:0]            wr_clr;
      logic [NUM_PORTS-1:0][MSG_N-1:0] wr_msg;

      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_wsel
         logic wr_here;
         assign wr_here   = p_sel[p] & p_we[p] & (p_dir[p] == 1'(l));
         assign wr_cmd[p] = wr_here & (p_field[p] == FLD_CMD);
         assign wr_clr[p] = wr_here & (p_field[p] == FLD_CLR);
         assign wr_msg[p] = (wr_here && p_field[p] == FLD_MSG) ? p_msg_sel[p] : '0;
      end

      mbx_lane #(
         .DATA_W (DATA_W),
         .CHAN_N (CHAN_N),
         .MSG_N  (MSG_N)
      ) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_cmd (wr_cmd),
         .wr_clr (wr_clr),
         .wr_msg (wr_msg),
         .wdata  (p_wdata),
         .cmd    (lane_cmd[l]),
         .msg    (lane_msg[l]),
         .irq    (lane_irq[l])
      );
   end

   assign host_rdata  = p_rdata[PORT_HOST];
   assign dsp_rdata   = p_rdata[PORT_DSP];
   assign irq_to_dsp  = lane_irq[0];
   assign irq_to_host = lane_irq[1];

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
   parameter int DATA_W = 32,
   parameter int CHAN_N = 5,
   parameter int MSG_N  = 5,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_sel,
   input logic              host_we,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] host_rdata,
   input logic              dsp_sel,
   input logic              dsp_we,
   input logic [ADDR_W-1:0] dsp_addr,
   input logic [DATA_W-1:0] dsp_wdata,
   input logic              irq_to_dsp,
   input logic [CHAN_N-1:0] in_cmd
);
   localparam logic [ADDR_W-1:0] A_IN_CMD = '0;
   localparam logic [ADDR_W-1:0] A_IN_CLR = ADDR_W'(1);
   localparam logic [ADDR_W:0]   MAP_X    = (ADDR_W+1)'(2 * (2 + MSG_N));

   logic host_in_set, dsp_in_set, host_in_clr, dsp_in_clr;
   assign host_in_set = host_sel && host_we && host_addr == A_IN_CMD;
   assign dsp_in_set  = dsp_sel  && dsp_we  && dsp_addr  == A_IN_CMD;
   assign host_in_clr = host_sel && host_we && host_addr == A_IN_CLR;
   assign dsp_in_clr  = dsp_sel  && dsp_we  && dsp_addr  == A_IN_CLR;

   // R3
   cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_in_clr || dsp_in_clr) |=> ((in_cmd & $past(in_cmd)) == $past(in_cmd)));

   // R5
   clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_in_clr && !dsp_in_set) |=> ((in_cmd & $past(host_wdata[CHAN_N-1:0])) == '0));

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_in_set |=> ((in_cmd & $past(dsp_wdata[CHAN_N-1:0])) == $past(dsp_wdata[CHAN_N-1:0])));

   // R4
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_to_dsp) |-> ($past(host_in_set && host_wdata[CHAN_N-1:0] != '0) ||
                             $past(dsp_in_set && dsp_wdata[CHAN_N-1:0] != '0)));

   // R9
   clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && !host_we && host_addr == A_IN_CLR) |=> (host_rdata == '0));

   // R10
   oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && !host_we && {1'b0, host_addr} >= MAP_X) |=> (host_rdata == '0));

endmodule

bind ipc_mailbox mbx_chk #(
   .DATA_W (DATA_W),
   .CHAN_N (CHAN_N),
   .MSG_N  (MSG_N),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_sel   (host_sel),
   .host_we    (host_we),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .dsp_sel    (dsp_sel),
   .dsp_we     (dsp_we),
   .dsp_addr   (dsp_addr),
   .dsp_wdata  (dsp_wdata),
   .irq_to_dsp (irq_to_dsp),
   .in_cmd     (lane_cmd[0])
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 32;

   localparam logic [AW-1:0] A_IN_CMD  = 4'd0;
   localparam logic [AW-1:0] A_IN_CLR  = 4'd1;
   localparam logic [AW-1:0] A_IN_MSG  = 4'd2;
   localparam logic [AW-1:0] A_OUT_CMD = 4'd7;
   localparam logic [AW-1:0] A_OUT_CLR = 4'd8;
   localparam logic [AW-1:0] A_OUT_MSG = 4'd9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_sel = 1'b0, host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          dsp_sel = 1'b0, dsp_we = 1'b0;
   logic [AW-1:0] dsp_addr = '0;
   logic [DW-1:0] dsp_wdata = '0;
   logic [DW-1:0] dsp_rdata;
   logic          irq_to_dsp, irq_to_host;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [DW-1:0] qh_data[$];
   string         qh_tag[$];
   logic [DW-1:0] qd_data[$];
   string         qd_tag[$];
   logic          h_rd_q = 1'b0, d_rd_q = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_mailbox dut_i (
      .clk (clk), .rst_n (rst_n),
      .host_sel (host_sel), .host_we (host_we), .host_addr (host_addr),
      .host_wdata (host_wdata), .host_rdata (host_rdata),
      .dsp_sel (dsp_sel), .dsp_we (dsp_we), .dsp_addr (dsp_addr),
      .dsp_wdata (dsp_wdata), .dsp_rdata (dsp_rdata),
      .irq_to_dsp (irq_to_dsp), .irq_to_host (irq_to_host)
   );

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // monitor: compare registered read data one cycle after each read
   always @(posedge clk) begin
      h_rd_q <= host_sel && !host_we;
      d_rd_q <= dsp_sel && !dsp_we;
   end

   always @(negedge clk) begin
      if (h_rd_q) begin
         if (qh_data.size() == 0) check(host_rdata, 'x, "R11 host unexpected read");
         else check(host_rdata, qh_data.pop_front(), qh_tag.pop_front());
      end
      if (d_rd_q) begin
         if (qd_data.size() == 0) check(dsp_rdata, 'x, "R11 dsp unexpected read");
         else check(dsp_rdata, qd_data.pop_front(), qd_tag.pop_front());
      end
   end

   // one access per port in the same cycle; port idle when sel bit is 0
   task automatic dual(input bit hs, input bit hw, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                       input bit ds, input bit dw, input logic [AW-1:0] da, input logic [DW-1:0] dd,
                       input string tag);
      @(negedge clk);
      host_sel = hs; host_we = hw; host_addr = ha; host_wdata = hd;
      dsp_sel = ds;  dsp_we = dw;  dsp_addr = da;  dsp_wdata = dd;
      if (hs && !hw) begin qh_data.push_back(hd); qh_tag.push_back({tag, " host"}); end
      if (ds && !dw) begin qd_data.push_back(dd); qd_tag.push_back({tag, " dsp"}); end
      @(posedge clk);
      #1;
      host_sel = 1'b0; host_we = 1'b0;
      dsp_sel = 1'b0;  dsp_we = 1'b0;
   endtask

   // port 0 = host, 1 = dsp; for reads d is the expected value
   task automatic wr(input bit port, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      if (port == 1'b0) dual(1, 1, a, d, 0, 0, '0, '0, tag);
      else              dual(0, 0, '0, '0, 1, 1, a, d, tag);
   endtask

   task automatic rd(input bit port, input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      if (port == 1'b0) dual(1, 0, a, exp, 0, 0, '0, '0, tag);
      else              dual(0, 0, '0, '0, 1, 0, a, exp, tag);
   endtask

   task automatic irq_is(input bit ed, input bit eh, input string tag);
      @(negedge clk);
      check({31'd0, irq_to_dsp},  {31'd0, ed}, {tag, " irq_to_dsp"});
      check({31'd0, irq_to_host}, {31'd0, eh}, {tag, " irq_to_host"});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state, R10 offsets 14/15 read zero
      irq_is(0, 0, "R1");
      for (int i = 0; i < 16; i++) rd(0, AW'(i), '0, "R1 reset word");

      // R2 R4 inbound ring raises the DSP interrupt
      wr(0, A_IN_CMD, 32'h1, "R4");
      irq_is(1, 0, "R4 ring dsp");
      rd(1, A_IN_CMD, 32'h1, "R2 inbound doorbell");

      // R3 set preserves earlier bits, zero write does nothing
      wr(0, A_IN_CMD, 32'h4, "R3");
      rd(1, A_IN_CMD, 32'h5, "R3 or-set");
      wr(0, A_IN_CMD, 32'h0, "R3");
      rd(1, A_IN_CMD, 32'h5, "R3 zero write");

      // R5 write-ones-to-clear
      wr(1, A_IN_CLR, 32'h1, "R5");
      rd(1, A_IN_CMD, 32'h4, "R5 partial clear");
      irq_is(1, 0, "R5 still pending");
      wr(1, A_IN_CLR, 32'hFFFF_FFFB, "R5");
      rd(1, A_IN_CMD, 32'h4, "R5 zero bit keeps");
      wr(1, A_IN_CLR, 32'h4, "R5");
      irq_is(0, 0, "R5 all cleared");

      // R9 zero extension, clear reads zero; outbound drives host irq (R4)
      wr(1, A_OUT_CMD, 32'hFFFF_FFFF, "R9");
      irq_is(0, 1, "R4 ring host");
      rd(0, A_OUT_CMD, 32'h1F, "R9 zero extend");
      rd(0, A_OUT_CLR, 32'h0, "R9 clear reads zero");
      wr(0, A_OUT_CLR, 32'h1F, "R5");
      irq_is(0, 0, "R5 outbound cleared");

      // R6 set beats coincident clear
      wr(0, A_IN_CMD, 32'h2, "R6");
      dual(1, 1, A_IN_CLR, 32'h2, 1, 1, A_IN_CMD, 32'h2, "R6");
      rd(1, A_IN_CMD, 32'h2, "R6 set wins");
      dual(1, 1, A_IN_CLR, 32'h3, 1, 1, A_IN_CMD, 32'h1, "R6");
      rd(1, A_IN_CMD, 32'h1, "R6 mixed set/clear");
      wr(1, A_IN_CLR, 32'h1, "R6");

      // R7 simultaneous sets merge
      dual(1, 1, A_OUT_CMD, 32'h1, 1, 1, A_OUT_CMD, 32'h8, "R7");
      rd(0, A_OUT_CMD, 32'h9, "R7 merged");
      wr(0, A_OUT_CLR, 32'h9, "R7");
      irq_is(0, 0, "R7 idle");

      // R8 scratch banks across ports
      for (int i = 0; i < 5; i++) begin
         wr(0, A_IN_MSG + AW'(i), 32'hA000_0000 | i, "R8");
         wr(1, A_OUT_MSG + AW'(i), 32'hB000_0000 | i, "R8");
      end
      for (int i = 0; i < 5; i++) begin
         rd(1, A_IN_MSG + AW'(i), 32'hA000_0000 | i, "R8 inbound word");
         rd(0, A_OUT_MSG + AW'(i), 32'hB000_0000 | i, "R8 outbound word");
      end
      dual(1, 1, A_OUT_MSG + 4'd2, 32'h1111_1111, 1, 1, A_OUT_MSG + 4'd2, 32'h2222_2222, "R8");
      rd(1, A_OUT_MSG + 4'd2, 32'h1111_1111, "R8 host priority");

      // R10 out-of-range writes touch nothing
      dual(1, 1, 4'd14, 32'hFFFF_FFFF, 1, 1, 4'd15, 32'hFFFF_FFFF, "R10");
      rd(0, 4'd14, 32'h0, "R10 read 14");
      rd(1, 4'd15, 32'h0, "R10 read 15");
      rd(0, A_IN_MSG, 32'hA000_0000, "R10 msg intact");
      rd(0, A_IN_CMD, 32'h0, "R10 doorbell intact");
      irq_is(0, 0, "R10");

      // R11 read-before-write on collision
      dual(1, 0, A_IN_MSG + 4'd1, 32'hA000_0001, 1, 1, A_IN_MSG + 4'd1, 32'h55, "R11 old value");
      rd(0, A_IN_MSG + 4'd1, 32'h55, "R11 new value");

      repeat (3) @(negedge clk);
      check(32'(qh_data.size() + qd_data.size()), 32'h0, "R11 reads outstanding");
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule